// File: doc/BRIEF.md
# Busy-Gated Register Write Guard

This block sits on the register-write path in front of an SD host controller core. Some control registers in that core must not be written while the card bus is active. For those targets, the guard accepts the write and holds it. It then polls one status bit at a fixed interval until the bus reports idle. Only then does it hand the write to the core. All other targets are forwarded on the next cycle with no polling.

Two status bits can report idle, and they have opposite sense. The command-busy bit reads 1 while the bus is active. The clock-divider-enable bit reads 0 while the bus is active. The clock-control target always waits on the clock-divider-enable bit. The other guarded targets wait on the command-busy bit only when the command-busy capability input is set and the controller version is not the one variant built without that bit. Otherwise they also fall back to the clock-divider-enable bit.

Polls are spaced one microsecond apart, timed by a prescaler of `CYC_PER_US` clock cycles. If the bus is still busy at the last of `POLL_LIMIT` polls, the held write is discarded and a sticky timeout flag is raised. The upstream side uses a valid/ready handshake, and only one write is held at a time.

Top module: `wg_write_guard`

## Requirements
- R1: While `rst_n` is low and right after it rises: `wr_ready` = 1, `core_wr_en` = 0, `busy_timeout` = 0.
- R2: A write accepted (`wr_valid` & `wr_ready` at a clock edge) to an address outside the guarded set is presented on `core_wr_en`/`core_wr_addr`/`core_wr_data` right after that edge, whatever the status bits hold.
- R3: Guarded set A is command 8'h00, stop-action 8'h01, block count 8'h02, transfer length 8'h03, card option 8'h04, transaction control 8'h05, DMA enable 8'h06 and host mode 8'h07. When `cap_cmd_busy` = 1 and `ctrl_version` differs from `NO_CBSY_VER`, a write to set A waits until a poll sees `stat_cmd_busy` = 0.
- R4: When `cap_cmd_busy` = 0, a write to set A waits until a poll sees `stat_clkdiv_en` = 1. `stat_cmd_busy` is ignored in this case.
- R5: A write to clock control 8'h12 always waits on `stat_clkdiv_en` = 1, even when `cap_cmd_busy` = 1.
- R6: When `ctrl_version` equals `NO_CBSY_VER`, a write to set A behaves as if `cap_cmd_busy` = 0.
- R7: The first poll happens at the edge after acceptance. Each later poll follows `CYC_PER_US` edges after the previous one. A write whose n-th poll (counting from 0) is the first to see idle is issued right after edge 1 + n·`CYC_PER_US`, counted from the accept edge as edge 0.
- R8: If all `POLL_LIMIT` polls see busy, the write is never issued. In that case `busy_timeout` rises and `wr_ready` returns to 1 right after the edge of the last poll.
- R9: `busy_timeout` stays 1 until an edge at which `err_clear` = 1, and reads 0 after that edge. A new timeout at the same edge takes priority over the clear.
- R10: `wr_ready` is 0 from acceptance of a guarded write until it is issued or dropped. `core_wr_en` is a single-cycle pulse, and `wr_ready` is 0 during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Upstream write request |
| wr_ready | output | 1 | Guard can take a write |
| wr_addr | input | 8 | Target register address |
| wr_data | input | DW | Write data |
| cap_cmd_busy | input | 1 | Command-busy status bit is available |
| ctrl_version | input | VER_W | Controller version code |
| stat_cmd_busy | input | 1 | Status: 1 = command busy |
| stat_clkdiv_en | input | 1 | Status: 0 = bus busy (clock divider not enabled) |
| err_clear | input | 1 | Clears the sticky timeout flag |
| core_wr_en | output | 1 | One-cycle write strobe to the core |
| core_wr_addr | output | 8 | Address presented to the core |
| core_wr_data | output | DW | Data presented to the core |
| busy_timeout | output | 1 | Sticky idle-wait timeout flag |

## Verification
The accept edge is edge 0. An unguarded write is expected on the strobe right after edge 0. A guarded write whose n-th poll first sees idle is expected right after edge 1 + n·`CYC_PER_US`, and a timeout raises the flag right after edge 1 + (`POLL_LIMIT`−1)·`CYC_PER_US`. The bench samples every falling edge after acceptance and records the index of the first strobe. It compares that index with the one computed from the vector. It drops the watched status bit to idle at the falling edge just after the last poll that must see busy, so each poll sees a known value. The bit that must not be watched is held at its idle value throughout. A guard that watches the wrong bit or uses the wrong sense therefore issues the write early or late.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned GUARD_N = 8;

  // Targets that wait on the capability-selected status bit
  localparam logic [ADDR_W-1:0] GUARD_LIST [GUARD_N] = '{
    8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07
  };
  // Target that always waits on the clock-divider-enable bit
  localparam logic [ADDR_W-1:0] ADDR_CLK_CTL = 8'h12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_ISSUE = 2'd2
  } wg_state_e;

  typedef enum logic {
    SRC_CLKDIV  = 1'b0,
    SRC_CMDBUSY = 1'b1
  } wg_src_e;
endpackage

// File: rtl/wg_addr_decode.sv
module wg_addr_decode
  import wg_pkg::*;
#(
  parameter int unsigned      VER_W       = 16,
  parameter logic [VER_W-1:0] NO_CBSY_VER = 16'h5A10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cap_cmd_busy,
  input  logic [VER_W-1:0]  ctrl_version,
  output logic              guarded,
  output wg_src_e           src
);
  logic in_list;
  logic is_clk;
  logic cbsy_usable;

  always_comb begin
    in_list = 1'b0;
    for (int i = 0; i < int'(GUARD_N); i++) begin
      if (addr == GUARD_LIST[i]) in_list = 1'b1;
    end
    is_clk      = (addr == ADDR_CLK_CTL);
    cbsy_usable = cap_cmd_busy && (ctrl_version != NO_CBSY_VER);
    guarded     = in_list || is_clk;
    src         = (in_list && cbsy_usable) ? SRC_CMDBUSY : SRC_CLKDIV;
  end
endmodule

// File: rtl/wg_poll_timer.sv
module wg_poll_timer #(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic poll_now,
  output logic last_poll
);
  localparam int unsigned PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmr_en;

  assign poll_now  = run && (pre_q == '0);
  assign last_poll = (cnt_q == CNT_W'(POLL_LIMIT - 1));
  assign tmr_en    = start || run;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (start) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (run) begin
      pre_d = (pre_q == PRE_W'(CYC_PER_US - 1)) ? '0 : pre_q + 1'b1;
      if (poll_now) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tmr_en) begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wg_err_flag.sv
module wg_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;
  logic flag_en;

  assign flag_en = set || clr;

  always_comb begin
    flag_d = set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/wg_write_guard.sv
module wg_write_guard
  import wg_pkg::*;
#(
  parameter int unsigned      DW          = 16,
  parameter int unsigned      VER_W       = 16,
  parameter logic [VER_W-1:0] NO_CBSY_VER = 16'h5A10,
  parameter int unsigned      CYC_PER_US  = 100,
  parameter int unsigned      POLL_LIMIT  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              cap_cmd_busy,
  input  logic [VER_W-1:0]  ctrl_version,
  input  logic              stat_cmd_busy,
  input  logic              stat_clkdiv_en,
  input  logic              err_clear,
  output logic              core_wr_en,
  output logic [ADDR_W-1:0] core_wr_addr,
  output logic [DW-1:0]     core_wr_data,
  output logic              busy_timeout
);
  wg_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  wg_src_e           src_q;
  wg_src_e           dec_src;
  logic              dec_guarded;
  logic              accept;
  logic              poll_now;
  logic              last_poll;
  logic              bus_idle;
  logic              timeout_hit;

  wg_addr_decode #(
    .VER_W       (VER_W),
    .NO_CBSY_VER (NO_CBSY_VER)
  ) u_dec (
    .addr         (wr_addr),
    .cap_cmd_busy (cap_cmd_busy),
    .ctrl_version (ctrl_version),
    .guarded      (dec_guarded),
    .src          (dec_src)
  );

  wg_poll_timer #(
    .CYC_PER_US (CYC_PER_US),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .run       (state_q == ST_POLL),
    .poll_now  (poll_now),
    .last_poll (last_poll)
  );

  wg_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (timeout_hit),
    .clr   (err_clear),
    .flag  (busy_timeout)
  );

  assign wr_ready     = (state_q == ST_IDLE);
  assign accept       = wr_valid && wr_ready;
  // Opposite sense: command-busy is 1 when busy, divider-enable is 0 when busy
  assign bus_idle     = (src_q == SRC_CMDBUSY) ? !stat_cmd_busy : stat_clkdiv_en;
  assign timeout_hit  = (state_q == ST_POLL) && poll_now && !bus_idle && last_poll;
  assign core_wr_en   = (state_q == ST_ISSUE);
  assign core_wr_addr = addr_q;
  assign core_wr_data = data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = dec_guarded ? ST_POLL : ST_ISSUE;
      end
      ST_POLL: begin
        if (poll_now) begin
          if (bus_idle)       state_d = ST_ISSUE;
          else if (last_poll) state_d = ST_IDLE;
        end
      end
      ST_ISSUE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      src_q  <= SRC_CLKDIV;
    end else if (accept) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
      src_q  <= dec_src;
    end
  end
endmodule

// File: rtl/wg_write_guard_chk.sv
module wg_write_guard_chk
  import wg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              core_wr_en,
  input logic [ADDR_W-1:0] core_wr_addr,
  input logic              busy_timeout,
  input logic              err_clear
);
  logic open_addr;

  always_comb begin
    open_addr = (wr_addr != ADDR_CLK_CTL);
    for (int i = 0; i < int'(GUARD_N); i++) begin
      if (wr_addr == GUARD_LIST[i]) open_addr = 1'b0;
    end
  end

  assert_fwd_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && open_addr) |=> (core_wr_en && core_wr_addr == $past(wr_addr)));

  assert_drop_on_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_timeout) |-> (!core_wr_en && wr_ready));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_timeout && !err_clear) |=> busy_timeout);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_en |=> !core_wr_en);

  assert_stall_on_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_en |-> !wr_ready);
endmodule

bind wg_write_guard wg_write_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .core_wr_en   (core_wr_en),
  .core_wr_addr (core_wr_addr),
  .busy_timeout (busy_timeout),
  .err_clear    (err_clear)
);

// File: tb/sim_wg_write_guard.sv
module sim_wg_write_guard;
  localparam int          CLK_PERIOD = 10;
  localparam int          C          = 3;
  localparam int          L          = 5;
  localparam logic [15:0] VER_X      = 16'h5A10;
  localparam int          NV         = 11;
  localparam int          KMAX       = 1 + L * C + 2;

  // {addr[15:8], cap[7], ver_excluded[6], busy_polls[5:2], watch_cmd_busy[1], guarded[0]}
  localparam logic [15:0] TBL [NV] = '{
    {8'h20, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0},  // R2 open address
    {8'h00, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1},  // R3 idle at first poll
    {8'h00, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1},  // R3 R7
    {8'h05, 1'b0, 1'b0, 4'd1, 1'b0, 1'b1},  // R4
    {8'h12, 1'b1, 1'b0, 4'd3, 1'b0, 1'b1},  // R5
    {8'h06, 1'b1, 1'b1, 4'd2, 1'b0, 1'b1},  // R6
    {8'h03, 1'b0, 1'b0, 4'd1, 1'b0, 1'b1},  // R4
    {8'h02, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1},  // R3
    {8'h04, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1},  // R3
    {8'h07, 1'b1, 1'b0, 4'd4, 1'b1, 1'b1},  // R7 last poll wins
    {8'h01, 1'b1, 1'b0, 4'd5, 1'b1, 1'b1}   // R8 timeout
  };

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        cap_cmd_busy;
  logic [15:0] ctrl_version;
  logic        stat_cmd_busy;
  logic        stat_clkdiv_en;
  logic        err_clear;
  logic        core_wr_en;
  logic [7:0]  core_wr_addr;
  logic [15:0] core_wr_data;
  logic        busy_timeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  wg_write_guard #(
    .DW          (16),
    .VER_W       (16),
    .NO_CBSY_VER (VER_X),
    .CYC_PER_US  (C),
    .POLL_LIMIT  (L)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .cap_cmd_busy   (cap_cmd_busy),
    .ctrl_version   (ctrl_version),
    .stat_cmd_busy  (stat_cmd_busy),
    .stat_clkdiv_en (stat_clkdiv_en),
    .err_clear      (err_clear),
    .core_wr_en     (core_wr_en),
    .core_wr_addr   (core_wr_addr),
    .core_wr_data   (core_wr_data),
    .busy_timeout   (busy_timeout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int e);
    case (e)
      0:       return "R2";
      1, 7, 8: return "R3";
      2:       return "R3 R7";
      3, 6:    return "R4";
      4:       return "R5";
      5:       return "R6";
      9:       return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    cap_cmd_busy = 1'b0; ctrl_version = 16'h1234;
    stat_cmd_busy = 1'b1; stat_clkdiv_en = 1'b0; err_clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_ready == 1'b1,     "R1", "ready in reset",   wr_ready,     1);
    chk(core_wr_en == 1'b0,   "R1", "strobe in reset",  core_wr_en,   0);
    chk(busy_timeout == 1'b0, "R1", "timeout in reset", busy_timeout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1 && !core_wr_en && !busy_timeout, "R1", "idle after reset",
        {wr_ready, core_wr_en, busy_timeout}, 3'b100);

    for (int e = 0; e < NV; e++) begin
      logic [7:0]  a;
      logic [15:0] d;
      bit cap, vex, wcb, grd;
      int b, exp_k, seen, tk;
      a = TBL[e][15:8]; cap = TBL[e][7]; vex = TBL[e][6];
      b = int'(TBL[e][5:2]); wcb = TBL[e][1]; grd = TBL[e][0];
      d = 16'h1111 * 16'(e) + 16'h0005;
      exp_k = !grd ? 0 : (b < L ? 1 + b * C : -1);
      tk = 1 + (L - 1) * C;
      cap_cmd_busy = cap;
      ctrl_version = vex ? VER_X : 16'h1234;
      if (!grd) begin
        stat_cmd_busy = 1'b1; stat_clkdiv_en = 1'b0;
      end else if (wcb) begin
        stat_clkdiv_en = 1'b1; stat_cmd_busy = (b != 0);
      end else begin
        stat_cmd_busy = 1'b0; stat_clkdiv_en = (b == 0);
      end
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      seen = -1;
      for (int k = 0; k <= KMAX; k++) begin
        if (k > 0) @(negedge clk);
        if (core_wr_en) begin
          if (seen < 0) begin
            seen = k;
            chk(core_wr_addr == a, tag_of(e), "issued address", core_wr_addr, a);
            chk(core_wr_data == d, tag_of(e), "issued data",    core_wr_data, d);
          end else begin
            chk(1'b0, "R10", "second strobe", k, seen);
          end
        end
        if (k == 0 && grd)
          chk(wr_ready == 1'b0, "R10", "stall while waiting", wr_ready, 0);
        if (grd && b > 0 && b <= L && k == 1 + (b - 1) * C) begin
          if (wcb) stat_cmd_busy = 1'b0;
          else     stat_clkdiv_en = 1'b1;
        end
        if (exp_k < 0 && k == tk - 1)
          chk(busy_timeout == 1'b0, "R8", "flag before last poll", busy_timeout, 0);
        if (exp_k < 0 && k == tk) begin
          chk(busy_timeout == 1'b1, "R8", "flag after last poll", busy_timeout, 1);
          chk(wr_ready == 1'b1,     "R8", "ready after drop",     wr_ready,     1);
        end
      end
      chk(seen == exp_k, tag_of(e), $sformatf("strobe edge of entry %0d", e), seen, exp_k);
    end

    repeat (4) @(negedge clk);
    chk(busy_timeout == 1'b1, "R9", "flag held", busy_timeout, 1);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk(busy_timeout == 1'b0, "R9", "flag cleared", busy_timeout, 0);
    @(negedge clk);
    chk(busy_timeout == 1'b0 && wr_ready == 1'b1, "R9", "clear persists",
        {busy_timeout, wr_ready}, 2'b01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule